// File: doc/BRIEF.md
# Pause Frame Receive Validator

This block sits on the receive byte stream of a full-duplex Ethernet MAC and decides, frame by frame, whether a frame is a valid standard flow-control pause request. It compares the header bytes against the expected values as they arrive, one byte per accepted beat. At the end of the frame it checks the error flag and the priority-flow-control state. It then issues a one-cycle quantum load strobe with the extracted 16-bit pause time and one of two interrupt pulses, and it advances a statistics counter.

Header layout, counted from the start-of-frame byte as byte 0: destination address in bytes 0-5, source address in bytes 6-11, type in bytes 12-13, opcode in bytes 14-15, pause quantum in bytes 16-17. Every multi-byte field arrives most significant byte first. Bytes after byte 17 are ignored.

Top module: `pause_rx_filter`

## Requirements
- R1: A frame is accepted only when bytes 0-5 equal `station_addr` (bit 47 down first) or equal 01-80-C2-00-00-01. Any other destination address has no effect on any output.
- R2: Bytes 12-13 must be 0x88, 0x08 and bytes 14-15 must be 0x00, 0x01. Otherwise the frame has no effect.
- R3: The quantum is {byte 16, byte 17}. For an accepted frame with `rx_pause_en` high, `quanta_load` is high for exactly the one cycle after the clock edge that takes the end-of-frame byte, and `quanta_value` then holds the quantum.
- R4: A frame whose end-of-frame byte carries `rx_err` high has no effect.
- R5: A frame that ends while `pfc_active` is high has no effect.
- R6: Every accepted frame loads its quantum, even when the frame immediately follows an earlier accepted frame.
- R7: An accepted frame with a non-zero quantum pulses `irq_nonzero` if `irq_en_nonzero` is high. One with a zero quantum pulses `irq_zero` if `irq_en_zero` is high. The two never pulse together.
- R8: `pause_count` increases by one, modulo 2^CNT_W, in the same cycle as the outcome of each accepted frame.
- R9: With `rx_pause_en` low, an accepted frame still updates `quanta_value`, raises the enabled interrupt and counts, but `quanta_load` stays low.
- R10: A frame that ends before byte 17 is not accepted. Longer frames are judged on bytes 0-17 alone.
- R11: After reset, `quanta_load`, `irq_nonzero`, `irq_zero`, `quanta_value` and `pause_count` are all zero.
- R12: Cycles with `rx_valid` low are skipped without moving the byte position. A start-of-frame byte restarts parsing at byte 0. Valid bytes outside a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Current byte is the first of a frame |
| rx_eof | input | 1 | Current byte is the last of a frame |
| rx_err | input | 1 | FCS or other error, valid with rx_eof |
| station_addr | input | 48 | Programmed station address |
| rx_pause_en | input | 1 | Allow accepted frames to load the quantum |
| pfc_active | input | 1 | Priority flow control has been negotiated |
| irq_en_nonzero | input | 1 | Enable for the non-zero quantum interrupt |
| irq_en_zero | input | 1 | Enable for the zero quantum interrupt |
| quanta_load | output | 1 | One-cycle load strobe for the pause quantum |
| quanta_value | output | 16 | Quantum of the latest accepted frame |
| irq_nonzero | output | 1 | Pulse: accepted frame with non-zero quantum |
| irq_zero | output | 1 | Pulse: accepted frame with zero quantum |
| pause_count | output | CNT_W | Count of accepted pause frames |

## Verification
The hardest case to produce is a frame that differs from a valid pause frame in only one byte or one end-of-frame qualifier. Such frames must leave every output untouched while frames around them are accepted. The bench sweeps destination kinds, including the station address with one byte flipped at each position, together with type and opcode faults, error and PFC flags, load and interrupt enables, boundary quanta and lengths of 17, 18 and 60 bytes. Some frames carry idle gaps. Separate sequences cover an abandoned partial frame followed by a restart, stray bytes outside a frame, and back-to-back reloads.

// File: rtl/pause_rx_pkg.sv
// Shared constants and types for the pause frame receive validator.
// Assumes the header layout: 6 B destination, 6 B source, 2 B type,
// 2 B opcode, 2 B quantum, all most significant byte first.
package pause_rx_pkg;
    localparam int          HDR_LEN     = 18;
    localparam int          IDX_W       = $clog2(HDR_LEN + 1);
    localparam logic [47:0] RSVD_DA     = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE   = 16'h8808;
    localparam logic [15:0] PAUSE_OPC   = 16'h0001;

    // Running verdict of the header parse, including the current byte
    typedef struct packed {
        logic        da_station;
        logic        da_rsvd;
        logic        hdr_ok;
        logic        complete;
        logic [15:0] quanta;
    } pause_parse_t;

    // Pick byte 'pos' (0 = most significant) of a 48-bit address
    function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [IDX_W-1:0] pos);
        logic [7:0] b;
        case (pos)
            IDX_W'(0): b = a[47:40];
            IDX_W'(1): b = a[39:32];
            IDX_W'(2): b = a[31:24];
            IDX_W'(3): b = a[23:16];
            IDX_W'(4): b = a[15:8];
            default:   b = a[7:0];
        endcase
        return b;
    endfunction
endpackage

// File: rtl/pause_hdr_match.sv
// Byte-serial header matcher. It tracks the byte position within a frame
// and folds each byte into running match flags. The verdict on the port
// already includes the byte present this cycle, so the end-of-frame byte
// can be judged without extra delay.
// Assumes rx_sof and rx_eof are only meaningful while rx_valid is high.
module pause_hdr_match
    import pause_rx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_valid,
    input  logic [7:0]   rx_data,
    input  logic         rx_sof,
    input  logic         rx_eof,
    input  logic [47:0]  station_addr,
    output logic         frame_end,
    output pause_parse_t parse
);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] SAT_POS  = IDX_W'(HDR_LEN);

    logic             in_frame;
    logic [IDX_W-1:0] idx;
    logic             st_q, rs_q, hdr_q, full_q;
    logic [7:0]       qhi_q, qlo_q;

    logic             take;
    logic [IDX_W-1:0] pos;
    logic             st_n, rs_n, hdr_n, full_n;
    logic [7:0]       qhi_n, qlo_n;

    // Purpose: fold the current byte into the match flags at its position
    always_comb begin
        take   = rx_valid && (rx_sof || in_frame);
        pos    = rx_sof ? '0 : idx;
        st_n   = rx_sof ? 1'b1 : st_q;
        rs_n   = rx_sof ? 1'b1 : rs_q;
        hdr_n  = rx_sof ? 1'b1 : hdr_q;
        full_n = rx_sof ? 1'b0 : full_q;
        qhi_n  = qhi_q;
        qlo_n  = qlo_q;
        if (pos < IDX_W'(6)) begin
            st_n = st_n && (rx_data == addr_byte(station_addr, pos));
            rs_n = rs_n && (rx_data == addr_byte(RSVD_DA, pos));
        end
        case (pos)
            IDX_W'(12): hdr_n = hdr_n && (rx_data == CTRL_TYPE[15:8]);
            IDX_W'(13): hdr_n = hdr_n && (rx_data == CTRL_TYPE[7:0]);
            IDX_W'(14): hdr_n = hdr_n && (rx_data == PAUSE_OPC[15:8]);
            IDX_W'(15): hdr_n = hdr_n && (rx_data == PAUSE_OPC[7:0]);
            IDX_W'(16): qhi_n = rx_data;
            IDX_W'(17): begin
                qlo_n  = rx_data;
                full_n = 1'b1;
            end
            default: ;
        endcase
        frame_end        = take && rx_eof;
        parse.da_station = st_n;
        parse.da_rsvd    = rs_n;
        parse.hdr_ok     = hdr_n;
        parse.complete   = full_n;
        parse.quanta     = {qhi_n, qlo_n};
    end

    // Purpose: advance the byte position and keep the running flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            idx      <= '0;
            st_q     <= 1'b0;
            rs_q     <= 1'b0;
            hdr_q    <= 1'b0;
            full_q   <= 1'b0;
            qhi_q    <= '0;
            qlo_q    <= '0;
        end else if (take) begin
            in_frame <= !rx_eof;
            idx      <= (pos > LAST_POS) ? SAT_POS : pos + IDX_W'(1);
            st_q     <= st_n;
            rs_q     <= rs_n;
            hdr_q    <= hdr_n;
            full_q   <= full_n;
            qhi_q    <= qhi_n;
            qlo_q    <= qlo_n;
        end
    end

    assert_idx_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= SAT_POS);
    assert_sof_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof) |=> (idx == IDX_W'(1)));
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(idx));
endmodule

// File: rtl/pause_rx_result.sv
// End-of-frame decision. It combines the header verdict with the error
// and PFC qualifiers and registers the load strobe, the interrupt pulses,
// the latest quantum and the statistics counter.
// Assumes the qualifiers and enables are valid in the end-of-frame cycle.
module pause_rx_result
    import pause_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  pause_parse_t     parse,
    input  logic             rx_err,
    input  logic             pfc_active,
    input  logic             rx_pause_en,
    input  logic             irq_en_nonzero,
    input  logic             irq_en_zero,
    output logic             quanta_load,
    output logic [15:0]      quanta_value,
    output logic             irq_nonzero,
    output logic             irq_zero,
    output logic [CNT_W-1:0] pause_count
);
    logic accept;
    logic q_zero;

    // Purpose: decide whether the frame ending now is a valid pause frame
    always_comb begin
        accept = frame_end && parse.complete && parse.hdr_ok
              && (parse.da_station || parse.da_rsvd)
              && !rx_err && !pfc_active;
        q_zero = (parse.quanta == 16'h0000);
    end

    // Purpose: register the outcome pulses, latest quantum and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quanta_load  <= 1'b0;
            quanta_value <= '0;
            irq_nonzero  <= 1'b0;
            irq_zero     <= 1'b0;
            pause_count  <= '0;
        end else begin
            quanta_load <= accept && rx_pause_en;
            irq_nonzero <= accept && !q_zero && irq_en_nonzero;
            irq_zero    <= accept && q_zero && irq_en_zero;
            if (accept) begin
                quanta_value <= parse.quanta;
                pause_count  <= pause_count + CNT_W'(1);
            end
        end
    end

    assert_err_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && rx_err) |=> !(quanta_load || irq_nonzero || irq_zero));
    assert_pfc_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && pfc_active) |=> $stable(pause_count));
    assert_irq_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_nonzero, irq_zero}) <= 1);
    assert_nz_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nonzero |-> (quanta_value != 16'h0000));
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        quanta_load |-> (pause_count == $past(pause_count) + CNT_W'(1)));
    assert_load_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_pause_en |=> !quanta_load);
endmodule

// File: rtl/pause_rx_filter.sv
// Top of the pause frame receive validator: a byte-serial header matcher
// feeding an end-of-frame decision stage. Outputs follow the end-of-frame
// byte by one clock.
// Assumes one byte per rx_valid beat and a full-duplex link.
module pause_rx_filter
    import pause_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic             rx_err,
    input  logic [47:0]      station_addr,
    input  logic             rx_pause_en,
    input  logic             pfc_active,
    input  logic             irq_en_nonzero,
    input  logic             irq_en_zero,
    output logic             quanta_load,
    output logic [15:0]      quanta_value,
    output logic             irq_nonzero,
    output logic             irq_zero,
    output logic [CNT_W-1:0] pause_count
);
    logic         frame_end;
    pause_parse_t parse;

    pause_hdr_match u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .station_addr (station_addr),
        .frame_end    (frame_end),
        .parse        (parse)
    );

    pause_rx_result #(.CNT_W(CNT_W)) u_result (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_end      (frame_end),
        .parse          (parse),
        .rx_err         (rx_err),
        .pfc_active     (pfc_active),
        .rx_pause_en    (rx_pause_en),
        .irq_en_nonzero (irq_en_nonzero),
        .irq_en_zero    (irq_en_zero),
        .quanta_load    (quanta_load),
        .quanta_value   (quanta_value),
        .irq_nonzero    (irq_nonzero),
        .irq_zero       (irq_zero),
        .pause_count    (pause_count)
    );
endmodule

// File: tb/tb_pause_rx_filter.sv
module tb_pause_rx_filter;
    localparam int CNT_W = 16;
    localparam logic [47:0] STATION = 48'h021122334455;
    localparam logic [47:0] RSVD    = 48'h0180C2000001;
    localparam logic [47:0] OTHER   = 48'h0180C2000002;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_pause_en = 1'b0, pfc_active = 1'b0, irq_en_nonzero = 1'b0, irq_en_zero = 1'b0;
    logic quanta_load, irq_nonzero, irq_zero;
    logic [15:0] quanta_value;
    logic [CNT_W-1:0] pause_count;

    int checks = 0;
    int failures = 0;
    int exp_count = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pause_rx_filter #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .station_addr(STATION), .rx_pause_en(rx_pause_en), .pfc_active(pfc_active),
        .irq_en_nonzero(irq_en_nonzero), .irq_en_zero(irq_en_zero),
        .quanta_load(quanta_load), .quanta_value(quanta_value),
        .irq_nonzero(irq_nonzero), .irq_zero(irq_zero), .pause_count(pause_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] frame_byte(input logic [47:0] da, input logic [15:0] ty,
                                              input logic [15:0] op, input logic [15:0] q, input int i);
        if (i < 6)       return da[8*(5-i) +: 8];
        else if (i < 12) return 8'hA0 + 8'(i);
        else if (i == 12) return ty[15:8];
        else if (i == 13) return ty[7:0];
        else if (i == 14) return op[15:8];
        else if (i == 15) return op[7:0];
        else if (i == 16) return q[15:8];
        else if (i == 17) return q[7:0];
        else             return 8'(i * 7);
    endfunction

    // Drive one frame; with_sof=0 sends the same bytes as strays
    task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                        input logic [15:0] q, input int len, input bit err, input bit gaps,
                        input bit with_sof, input bit with_eof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                rx_valid = 1'b0;
                rx_data  = 8'h88;
                rx_sof   = 1'b1;
                rx_eof   = 1'b1;
                @(negedge clk);
            end
            rx_valid = 1'b1;
            rx_data  = frame_byte(da, ty, op, q, i);
            rx_sof   = with_sof && (i == 0);
            rx_eof   = with_eof && (i == len - 1);
            rx_err   = err && (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        rx_err   = 1'b0;
    endtask

    // Check outputs in the cycle after the end-of-frame byte, then one later
    task automatic expect_outcome(input string tag, input bit ok, input logic [15:0] q);
        bit en_l = rx_pause_en;
        if (ok) exp_count++;
        chk({tag, " R3 R9 load"}, 32'(quanta_load), 32'(ok && en_l));
        if (ok) chk({tag, " R3 value"}, 32'(quanta_value), 32'(q));
        chk({tag, " R7 irq_nonzero"}, 32'(irq_nonzero), 32'(ok && q != 0 && irq_en_nonzero));
        chk({tag, " R7 irq_zero"}, 32'(irq_zero), 32'(ok && q == 0 && irq_en_zero));
        chk({tag, " R8 count"}, 32'(pause_count), 32'(exp_count % (1 << CNT_W)));
        @(negedge clk);
        chk({tag, " R3 single pulse"}, 32'({quanta_load, irq_nonzero, irq_zero}), 32'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 load", 32'(quanta_load), 0);
        chk("R11 irqs", 32'({irq_nonzero, irq_zero}), 0);
        chk("R11 value", 32'(quanta_value), 0);
        chk("R11 count", 32'(pause_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep: destination kind, header, error, pfc, enable, quantum, length
        begin
            int n = 0;
            for (int d = 0; d < 4; d++)
            for (int h = 0; h < 3; h++)
            for (int e = 0; e < 2; e++)
            for (int p = 0; p < 2; p++)
            for (int en = 0; en < 2; en++)
            for (int qi = 0; qi < 4; qi++)
            for (int li = 0; li < 3; li++) begin
                logic [47:0] da;
                logic [15:0] ty, op, q;
                int len;
                bit ok;
                string tag;
                da = (d == 0) ? STATION : (d == 1) ? RSVD : (d == 2) ? OTHER
                   : STATION ^ (48'h01 << (8 * (n % 6)));
                ty = (h == 1) ? 16'h8809 : 16'h8808;
                op = (h == 2) ? 16'h0101 : 16'h0001;
                q  = (qi == 0) ? 16'h0000 : (qi == 1) ? 16'h0001 : (qi == 2) ? 16'h1234 : 16'hFFFF;
                len = (li == 0) ? 17 : (li == 1) ? 18 : 60;
                pfc_active     = p[0];
                rx_pause_en    = en[0];
                irq_en_nonzero = n[0];
                irq_en_zero    = n[1];
                // R1 R2 R4 R5 R10: acceptance rule
                ok = (d < 2) && (h == 0) && (e == 0) && (p == 0) && (len >= 18);
                tag = $sformatf("sweep d%0d h%0d e%0d p%0d en%0d q%0h len%0d R1 R2 R4 R5 R10",
                                d, h, e, p, en, q, len);
                send(da, ty, op, q, len, e[0], (n % 5) == 0, 1'b1, 1'b1);
                expect_outcome(tag, ok, q);
                n++;
            end
        end

        pfc_active = 1'b0;
        rx_pause_en = 1'b1;
        irq_en_nonzero = 1'b1;
        irq_en_zero = 1'b1;

        // R6: back-to-back reloads replace the quantum each time
        send(RSVD, 16'h8808, 16'h0001, 16'h0500, 18, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_outcome("reload first R6", 1'b1, 16'h0500);
        send(STATION, 16'h8808, 16'h0001, 16'h0007, 18, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_outcome("reload second R6", 1'b1, 16'h0007);
        send(RSVD, 16'h8808, 16'h0001, 16'h0000, 20, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_outcome("reload zero R6", 1'b1, 16'h0000);

        // R12: abandoned partial frame, then a fresh start-of-frame restarts
        send(OTHER, 16'h8808, 16'h0001, 16'h0042, 9, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12 partial no effect", 32'({quanta_load, irq_nonzero, irq_zero}), 0);
        send(STATION, 16'h8808, 16'h0001, 16'h0042, 18, 1'b0, 1'b1, 1'b1, 1'b1);
        expect_outcome("restart R12", 1'b1, 16'h0042);

        // R12: valid-looking bytes outside any frame have no effect
        send(STATION, 16'h8808, 16'h0001, 16'h0099, 18, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_outcome("stray bytes R12", 1'b0, 16'h0099);
        chk("R12 stray value kept", 32'(quanta_value), 32'h42);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R3 actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule